// File: doc/BRIEF.md
# Clocked Serial Transmitter with Tail Mark

This block sends one 8-bit or 16-bit word, most significant bit first, on a serial data line. A shift clock times each bit. The shift clock is either generated inside the block, by dividing the system clock by a power of two, or taken from an external pin. Software uses a small register interface to do the following:

- load the two data bytes;
- pick the word length, the clock source and the divider;
- optionally request a tail mark, which is a short fixed pattern sent right after the data bits;
- start the transfer by writing a start bit.

The start bit clears itself when the last data bit has finished. In the same cycle, a sticky transfer-complete request is raised. That request reaches the interrupt pin only when its enable bit is set. While a tail mark is on the line, a separate status flag reads 1. To send words back to back, software repeats three steps: load the data, start, and wait for completion.

Register map (addr, 3 bits):

| Address | Name | Contents |
|---|---|---|
| 0 | CTRL | [0] wide (1 = 16-bit word); [1] mode_hi (must be 0 to transmit); [2] mark_en; [4:3] mark_sel; [5] ext_clk |
| 1 | PRESC | [2:0] k; the internal shift clock period is 2^(k+1) system clocks |
| 2 | DLO | low data byte |
| 3 | DHI | high data byte |
| 4 | STATUS | [0] start; [1] mark_busy; [2] irq_req |
| 5 | IEN | [0] interrupt enable |

Top module: `sctx_top`

## Requirements
- R1: After reset, sdo and sclk_o are 1, irq_o is 0, and STATUS and CTRL read 0.
- R2: Writing STATUS with bit0=1 sets start and launches a transfer only when the engine is idle and CTRL[1] is 0. With CTRL[1]=1 the write has no effect: start stays 0 and sdo stays 1.
- R3: Data leaves MSB first. sdo changes on each falling shift-clock edge and is meant to be sampled on the rising edge. An 8-bit word (CTRL[0]=0) sends only DLO[7:0]. A 16-bit word sends DHI[7:0] followed by DLO[7:0]. sdo is 1 whenever no transfer is running.
- R4: With CTRL[5]=0, the shift clock on sclk_o has a period of 2^(k+1) system clocks, where k is PRESC[2:0] (a divide range of 2 to 256). sclk_o idles high.
- R5: At the falling edge that ends the last data bit, STATUS[0] drops from 1 to 0 and STATUS[2] rises, both in the same cycle.
- R6: With CTRL[2]=1, a tail mark follows the data bits. CTRL[4:3] selects it: code 0 is low for one shift period, code 1 is high for one, code 2 is low for two, and code 3 is high for two. STATUS[1] reads 1 for exactly that many shift periods.
- R7: irq_o equals STATUS[2] AND IEN[0]. STATUS[2] stays set until STATUS is written with bit2=0. Writing bit2=1 leaves it unchanged.
- R8: Writes to CTRL and PRESC while a transfer or tail mark is in progress are ignored.
- R9: With CTRL[5]=1, each falling edge of the synchronized sclk_i advances one bit. Edges that arrive before start is set shift nothing.
- R10: Consecutive load and start sequences each send their own word correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data at addr |
| sclk_i | input | 1 | External shift clock |
| sclk_o | output | 1 | Internal shift clock, idle high |
| sdo | output | 1 | Serial data output, idle high |
| irq_o | output | 1 | Transfer-complete interrupt |

## Verification
The bench acts as a receiver, sampling sdo on each rising shift-clock edge. It runs many random words, word lengths, dividers and mark codes, and adds these directed cases:

- **Slowest divider.** Run a full 16-bit word at k=7. A design that sizes its counter too narrowly would produce the wrong sclk_o period.
- **Mark flag length.** Count the cycles STATUS[1] stays high. A design that ends the mark one period early would be caught.
- **Start and request together.** Watch the cycle where start falls and confirm irq_req rises in that same cycle, not one cycle later.
- **CTRL write mid-transfer.** Write CTRL while busy. A design that accepts the write would change the mark or word length, or read back the new value.
- **External clock edges before start.** Toggle sclk_i before the start write. A design that lets those edges through would have bits already shifted out and would send a short word.
- **Rejected start.** Write start with CTRL[1]=1. A design that does not reject it would drive data out.

// File: rtl/sctx_pkg.sv
package sctx_pkg;

    localparam int PRESC_W = 3;
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 2 * BYTE_W;
    localparam int SLOT_W  = $clog2(WORD_W + 3);
    localparam int CNT_W   = (1 << PRESC_W) - 1;

    typedef struct packed {
        logic       ext_clk;
        logic [1:0] mark_sel;
        logic       mark_en;
        logic       mode_hi;
        logic       wide;
    } ctrl_t;

    typedef enum logic [2:0] {
        A_CTRL  = 3'd0,
        A_PRESC = 3'd1,
        A_DLO   = 3'd2,
        A_DHI   = 3'd3,
        A_STAT  = 3'd4,
        A_IEN   = 3'd5
    } addr_e;

    // number of shift periods of a tail mark code
    function automatic logic [1:0] mark_len(input logic [1:0] sel);
        return sel[1] ? 2'd2 : 2'd1;
    endfunction

    // line level of a tail mark code
    function automatic logic mark_level(input logic [1:0] sel);
        return sel[0];
    endfunction

endpackage

// File: rtl/sctx_regs.sv
module sctx_regs
    import sctx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [2:0]          addr,
    input  logic [BYTE_W-1:0]   wdata,
    input  logic                eng_busy,
    input  logic                data_done,
    input  logic                mark_busy,
    output logic [BYTE_W-1:0]   rdata,
    output ctrl_t               ctrl,
    output logic [PRESC_W-1:0]  presc,
    output logic [BYTE_W-1:0]   data_lo,
    output logic [BYTE_W-1:0]   data_hi,
    output logic                go,
    output logic                start_q,
    output logic                irq_o
);

    logic irq_req;
    logic irq_en;
    logic stat_wr;

    assign stat_wr = wr_en && (addr == A_STAT);
    assign go      = stat_wr && wdata[0] && !eng_busy && !ctrl.mode_hi;
    assign irq_o   = irq_req && irq_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            presc   <= '0;
            data_lo <= '0;
            data_hi <= '0;
            irq_en  <= 1'b0;
            start_q <= 1'b0;
            irq_req <= 1'b0;
        end else begin
            if (wr_en) begin
                case (addr)
                    A_CTRL:  if (!eng_busy) ctrl  <= ctrl_t'(wdata[$bits(ctrl_t)-1:0]);
                    A_PRESC: if (!eng_busy) presc <= wdata[PRESC_W-1:0];
                    A_DLO:   data_lo <= wdata;
                    A_DHI:   data_hi <= wdata;
                    A_IEN:   irq_en  <= wdata[0];
                    default: ;
                endcase
            end
            if (go)
                start_q <= 1'b1;
            else if (data_done)
                start_q <= 1'b0;
            if (data_done)
                irq_req <= 1'b1;
            else if (stat_wr && !wdata[2])
                irq_req <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:  rdata = {{(BYTE_W-$bits(ctrl_t)){1'b0}}, ctrl};
            A_PRESC: rdata = {{(BYTE_W-PRESC_W){1'b0}}, presc};
            A_DLO:   rdata = data_lo;
            A_DHI:   rdata = data_hi;
            A_STAT:  rdata = {{(BYTE_W-3){1'b0}}, irq_req, mark_busy, start_q};
            A_IEN:   rdata = {{(BYTE_W-1){1'b0}}, irq_en};
            default: rdata = '0;
        endcase
    end

    // R8
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        eng_busy |=> ($stable(ctrl) && $stable(presc)));

    // R5
    done_flags_chk: assert property (@(posedge clk) disable iff (rst)
        data_done |=> (!start_q && irq_req));

    // R5
    fell_irq_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(start_q) |-> irq_req);

endmodule

// File: rtl/sctx_clkgen.sv
module sctx_clkgen
    import sctx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               active,
    input  logic               ext_sel,
    input  logic [PRESC_W-1:0] presc,
    input  logic               sclk_i,
    input  logic               hold,
    output logic               fall_ev,
    output logic               rise_ev,
    output logic               sclk_o
);

    localparam int HCNT_W = CNT_W + 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic [HCNT_W-1:0]      cnt_q;
    logic [HCNT_W-1:0]      half_m1;
    logic                   sclk_q;
    logic                   tick;
    logic                   ext_lvl;

    assign half_m1 = (HCNT_W'(1) << presc) - HCNT_W'(1);
    assign tick    = active && (cnt_q == half_m1);
    assign ext_lvl = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            prev_q <= 1'b1;
            cnt_q  <= '0;
            sclk_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], sclk_i};
            prev_q <= ext_lvl;
            if (!active || tick)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + HCNT_W'(1);
            if (!active)
                sclk_q <= 1'b1;
            else if (tick && !ext_sel && !hold)
                sclk_q <= ~sclk_q;
        end
    end

    always_comb begin
        if (ext_sel) begin
            fall_ev = active && prev_q && !ext_lvl;
            rise_ev = active && !prev_q && ext_lvl;
            sclk_o  = 1'b1;
        end else begin
            fall_ev = tick && sclk_q;
            rise_ev = tick && !sclk_q;
            sclk_o  = sclk_q;
        end
    end

endmodule

// File: rtl/sctx_engine.sv
module sctx_engine
    import sctx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  ctrl_t             ctrl,
    input  logic [BYTE_W-1:0] data_lo,
    input  logic [BYTE_W-1:0] data_hi,
    input  logic              fall_ev,
    output logic              sdo,
    output logic              active,
    output logic              mark_busy,
    output logic              data_done,
    output logic              finish
);

    logic [WORD_W-1:0] shreg;
    logic [SLOT_W-1:0] slot;
    logic [SLOT_W-1:0] n_bits;
    logic [SLOT_W-1:0] total;
    logic              wide_q;
    logic [1:0]        m_len;
    logic              m_lvl;

    assign n_bits    = wide_q ? SLOT_W'(WORD_W) : SLOT_W'(BYTE_W);
    assign total     = n_bits + SLOT_W'(m_len);
    assign data_done = active && fall_ev && (slot == n_bits);
    assign finish    = active && fall_ev && (slot == total);

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            mark_busy <= 1'b0;
            sdo       <= 1'b1;
            slot      <= '0;
            shreg     <= '0;
            wide_q    <= 1'b0;
            m_len     <= '0;
            m_lvl     <= 1'b0;
        end else if (go) begin
            active <= 1'b1;
            slot   <= '0;
            wide_q <= ctrl.wide;
            shreg  <= ctrl.wide ? {data_hi, data_lo} : {data_lo, {BYTE_W{1'b0}}};
            m_len  <= ctrl.mark_en ? mark_len(ctrl.mark_sel) : 2'd0;
            m_lvl  <= mark_level(ctrl.mark_sel);
        end else if (active && fall_ev) begin
            if (finish) begin
                active    <= 1'b0;
                mark_busy <= 1'b0;
                sdo       <= 1'b1;
            end else if (slot < n_bits) begin
                sdo   <= shreg[WORD_W-1];
                shreg <= {shreg[WORD_W-2:0], 1'b0};
                slot  <= slot + SLOT_W'(1);
            end else begin
                sdo       <= m_lvl;
                mark_busy <= 1'b1;
                slot      <= slot + SLOT_W'(1);
            end
        end
    end

    // R3
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        !active |-> sdo);

endmodule

// File: rtl/sctx_top.sv
module sctx_top
    import sctx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       sclk_i,
    output logic       sclk_o,
    output logic       sdo,
    output logic       irq_o
);

    ctrl_t              ctrl;
    logic [PRESC_W-1:0] presc;
    logic [BYTE_W-1:0]  data_lo;
    logic [BYTE_W-1:0]  data_hi;
    logic               go;
    logic               start_q;
    logic               eng_active;
    logic               mark_busy;
    logic               data_done;
    logic               finish;
    logic               fall_ev;
    logic               rise_ev;

    sctx_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .eng_busy  (eng_active),
        .data_done (data_done),
        .mark_busy (mark_busy),
        .rdata     (rdata),
        .ctrl      (ctrl),
        .presc     (presc),
        .data_lo   (data_lo),
        .data_hi   (data_hi),
        .go        (go),
        .start_q   (start_q),
        .irq_o     (irq_o)
    );

    sctx_clkgen #(.SYNC_STAGES(SYNC_STAGES)) u_clkgen (
        .clk     (clk),
        .rst     (rst),
        .active  (eng_active),
        .ext_sel (ctrl.ext_clk),
        .presc   (presc),
        .sclk_i  (sclk_i),
        .hold    (finish),
        .fall_ev (fall_ev),
        .rise_ev (rise_ev),
        .sclk_o  (sclk_o)
    );

    sctx_engine u_engine (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .ctrl      (ctrl),
        .data_lo   (data_lo),
        .data_hi   (data_hi),
        .fall_ev   (fall_ev),
        .sdo       (sdo),
        .active    (eng_active),
        .mark_busy (mark_busy),
        .data_done (data_done),
        .finish    (finish)
    );

    // R6
    busy_match_chk: assert property (@(posedge clk) disable iff (rst)
        eng_active == (start_q || mark_busy));

    // R6
    mark_excl_chk: assert property (@(posedge clk) disable iff (rst)
        mark_busy |-> !start_q);

    // R4
    edge_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(fall_ev && rise_ev));

endmodule

// File: tb/sctx_top_bench.sv
`timescale 1ns/1ps
module sctx_top_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd4;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       sclk_i = 1'b1;
    logic       sclk_o;
    logic       sdo;
    logic       irq_o;

    always #2 clk = ~clk;

    sctx_top u_sctx_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .sclk_i(sclk_i), .sclk_o(sclk_o), .sdo(sdo), .irq_o(irq_o)
    );

    int errors = 0;
    int checks = 0;
    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // receiver monitor
    bit          rx [1024];
    int unsigned rt [1024];
    int          rx_n = 0;
    int          done_ok = 0;
    int          done_bad = 0;
    int          mark_cyc = 0;
    logic        sclk_prev = 1'b1;
    logic [7:0]  st_prev = 8'h00;

    always @(negedge clk) begin
        if (!rst) begin
            if (sclk_o && !sclk_prev) begin
                rx[rx_n % 1024] = sdo;
                rt[rx_n % 1024] = cyc;
                rx_n = rx_n + 1;
            end
            sclk_prev = sclk_o;
            if (addr == 3'd4 && !wr_en) begin
                if (st_prev[0] && !rdata[0]) begin
                    if (rdata[2] && !st_prev[2]) done_ok = done_ok + 1;
                    else done_bad = done_bad + 1;
                end
                if (rdata[1]) mark_cyc = mark_cyc + 1;
                st_prev = rdata;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0; addr = 3'd4;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(posedge clk); #1;
        addr = a;
        @(negedge clk);
        d = rdata;
        @(posedge clk); #1;
        addr = 3'd4;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (rdata[1:0] == 2'b00) break;
        end
    endtask

    // expected serial pattern
    bit exp_b [20];
    int exp_n;
    int exp_m;
    task automatic build(input bit wide, input bit men, input logic [1:0] sel,
                         input logic [7:0] lo, input logic [7:0] hi);
        logic [15:0] w;
        int nb;
        nb = wide ? 16 : 8;
        w  = wide ? {hi, lo} : {lo, 8'h00};
        for (int i = 0; i < nb; i++) exp_b[i] = w[15-i];
        exp_m = men ? (sel[1] ? 2 : 1) : 0;
        for (int i = 0; i < exp_m; i++) exp_b[nb+i] = sel[0];
        exp_n = nb;
    endtask

    task automatic run_int(input int k, input bit wide, input bit men, input logic [1:0] sel,
                           input logic [7:0] lo, input logic [7:0] hi, input bit ien,
                           input bit poke_ctrl);
        logic [7:0] ctrl_v, st;
        int n0, d0, b0, m0, got, bad_d, bad_m, bad_t;
        ctrl_v = {2'b00, 1'b0, sel, men, 1'b0, wide};
        wr(3'd4, 8'h00);
        wr(3'd0, ctrl_v);
        wr(3'd1, k[7:0]);
        wr(3'd2, lo);
        wr(3'd3, hi);
        wr(3'd5, {7'd0, ien});
        build(wide, men, sel, lo, hi);
        n0 = rx_n; d0 = done_ok; b0 = done_bad; m0 = mark_cyc;
        wr(3'd4, 8'h01);
        if (poke_ctrl) begin
            wr(3'd0, ctrl_v ^ 8'h1D);
            wr(3'd1, 8'h07);
        end
        wait_idle();
        repeat (3) @(negedge clk);
        got = rx_n - n0;
        chk(got == exp_n + exp_m, "R3 R10 bit count", got, exp_n + exp_m);
        bad_d = 0; bad_m = 0; bad_t = 0;
        for (int i = 0; i < got && i < 20; i++) begin
            if (rx[(n0+i) % 1024] != exp_b[i]) begin
                if (i < exp_n) bad_d++; else bad_m++;
            end
            if (i > 0 && rt[(n0+i) % 1024] - rt[(n0+i-1) % 1024] != (2 << k)) bad_t++;
        end
        chk(bad_d == 0, "R3 R10 data bits", bad_d, 0);
        chk(bad_m == 0, "R6 tail mark bits", bad_m, 0);
        chk(bad_t == 0, "R4 shift period", bad_t, 0);
        chk(done_ok - d0 == 1 && done_bad == b0, "R5 start/irq same cycle", done_ok - d0, 1);
        chk(mark_cyc - m0 == exp_m * (2 << k), "R6 mark flag cycles", mark_cyc - m0, exp_m * (2 << k));
        chk(irq_o == ien, "R7 irq gating", irq_o, ien);
        if (poke_ctrl) begin
            rd(3'd0, st);
            chk(st == ctrl_v, "R8 ctrl locked", st, ctrl_v);
            rd(3'd1, st);
            chk(st == k[7:0], "R8 presc locked", st, k);
        end
        wr(3'd4, 8'h04);
        rd(3'd4, st);
        chk(st[2] == 1'b1, "R7 bit2=1 keeps request", st[2], 1);
        wr(3'd4, 8'h00);
        rd(3'd4, st);
        chk(st[2] == 1'b0 && irq_o == 1'b0, "R7 request cleared", st, 0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R10 watchdog actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] st;
        int n0, d0, bad;
        void'($urandom(32'h5EED1234));
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        @(negedge clk);
        chk(sdo == 1'b1 && sclk_o == 1'b1 && irq_o == 1'b0, "R1 idle pins", {sdo, sclk_o, irq_o}, 3'b110);
        rd(3'd4, st);
        chk(st == 8'h00, "R1 status", st, 0);
        rd(3'd0, st);
        chk(st == 8'h00, "R1 ctrl", st, 0);

        // R2 start rejected with mode_hi set
        wr(3'd0, 8'h02);
        n0 = rx_n;
        wr(3'd4, 8'h01);
        repeat (20) @(negedge clk);
        rd(3'd4, st);
        chk(st[0] == 1'b0 && sdo == 1'b1 && rx_n == n0, "R2 start ignored", st, 0);

        // directed corners
        run_int(0, 1'b0, 1'b0, 2'd0, 8'hA5, 8'h3C, 1'b1, 1'b0);
        run_int(7, 1'b1, 1'b1, 2'd3, 8'h81, 8'h7E, 1'b1, 1'b0);
        run_int(2, 1'b1, 1'b1, 2'd2, 8'h5A, 8'hC3, 1'b0, 1'b1);

        // R10 random back-to-back words
        for (int t = 0; t < 12; t++) begin
            run_int($urandom_range(0, 3), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    2'($urandom_range(0, 3)), 8'($urandom), 8'($urandom),
                    1'($urandom_range(0, 1)), 1'b0);
        end

        // R9 external clock
        wr(3'd4, 8'h00);
        wr(3'd0, 8'h20 | 8'h10 | 8'h04 | 8'h01);
        wr(3'd2, 8'h96);
        wr(3'd3, 8'h2B);
        wr(3'd5, 8'h01);
        build(1'b1, 1'b1, 2'd2, 8'h96, 8'h2B);
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1 sclk_i = 1'b0;
            repeat (8) @(posedge clk);
            #1 sclk_i = 1'b1;
            repeat (8) @(posedge clk);
        end
        chk(sdo == 1'b1, "R9 pre-start edges ignored", sdo, 1);
        d0 = done_ok;
        wr(3'd4, 8'h01);
        repeat (10) @(negedge clk);
        chk(rdata[0] == 1'b1 && sdo == 1'b1, "R9 nothing shifted before first edge", {rdata[0], sdo}, 2'b11);
        bad = 0;
        for (int i = 0; i <= exp_n + exp_m; i++) begin
            @(posedge clk); #1 sclk_i = 1'b0;
            repeat (10) @(negedge clk);
            if (i < exp_n + exp_m && sdo != exp_b[i]) bad++;
            @(posedge clk); #1 sclk_i = 1'b1;
            repeat (10) @(negedge clk);
        end
        chk(bad == 0, "R9 external clock bits", bad, 0);
        chk(rdata[1:0] == 2'b00 && sdo == 1'b1, "R9 idle after final edge", {rdata[1:0], sdo}, 3'b001);
        chk(done_ok - d0 == 1 && irq_o == 1'b1, "R5 R9 completion", done_ok - d0, 1);

        summary();
        $finish;
    end

endmodule